// File: doc/BRIEF.md
# Hybrid Pointer-Vector Directory Set

This block is one slice of a coherence directory, organised as a set-associative array of 128 sets with 8 ways each, tracking which of 16 cores hold a copy of each line. Most ways (six per set) are narrow: each holds one core number, or a flag meaning "every core". The remaining two ways per set are wide and hold a full per-core sharer bit-vector. A request carries an operation (lookup, add sharer, remove sharer), a line address and a core number. The response gives a hit flag and the line's sharer set, always expanded to a 16-bit vector.

When an add request would give a narrow entry a second sharer, the entry overflows. The line moves into a wide way holding both sharers, and whatever that wide way held moves into the freed narrow way. Displaced contents keep their exact sharer if only one core remains. Otherwise they become "every core". A miss that allocates takes a free narrow way, then a free wide way. When neither is free, it replaces the least recently used narrow way and reports the evicted line.

Control is a three-state machine. **ST_IDLE** holds ready high; the transition *accept* (valid while ready) latches the request and enters **ST_EXEC**. In ST_EXEC the set is read and updated. The transition *finish* returns to ST_IDLE, or the transition *overflow* enters **ST_SWAP**. ST_SWAP performs the exchange and always takes *swap_done* back to ST_IDLE. The address splits into a set index (bits 6:0) and a tag (bits 15:7).

Top module: `hdir_top`

## Requirements
- R1: `req_ready` is high only in the idle state and goes low in the cycle after a request is accepted. For a request that does not overflow, `rsp_valid` is a one-cycle pulse in the second cycle after the accepting edge.
- R2: An overflowing add takes one extra cycle, with `req_ready` low. Its response arrives in the third cycle after the accepting edge.
- R3: Operation codes are 0 = lookup, 1 = add sharer, 2 = remove sharer; code 3 acts as a lookup. A lookup returns hit=1 and the stored sharer set on a hit, and hit=0 with sharers 0 on a miss. It leaves every line's sharer set unchanged.
- R4: On an add, `rsp_hit` reports whether the line was present before the request, and `rsp_sharers` gives the set after it. An add to a line in a wide way sets that core's bit.
- R5: An add for a core a narrow entry already covers (its own core, or an every-core entry) changes nothing and does not overflow.
- R6: An add that misses fills the lowest-numbered free narrow way (ways 0 to 5), else the lowest-numbered free wide way (ways 6 and 7). The new line holds only the requesting core.
- R7: With no free way, a missing add replaces the least recently used narrow way. `evict_valid` pulses with the response, carrying the old line address and sharer set.
- R8: On overflow, the line moves to a wide way holding both sharers. The wide way chosen is the lowest free one if any; else the lowest one holding exactly one sharer; else the least recently used one.
- R9: The displaced wide-way contents go to the freed narrow way. They keep their exact sharer if exactly one remains, and read back as all 16 bits set if two or more remain. An empty displaced way leaves the narrow way free.
- R10: A remove clears the core's bit, and removing the last sharer frees the way. A remove on an every-core entry, on a narrow entry of another core, or on a missing line changes nothing. A valid wide way never holds an empty set.
- R11: A line address occupies at most one way of its set.
- R12: Each request that hits or allocates makes the touched way the most recent in its set. On overflow, the chosen wide way becomes the most recent. Recency forms a strict order over the 8 ways.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 2 | Operation code |
| req_addr | input | 16 | Line address (tag and set index) |
| req_core | input | 4 | Core number |
| rsp_valid | output | 1 | Response pulse |
| rsp_hit | output | 1 | Line was present before the request |
| rsp_sharers | output | 16 | Sharer set after the request |
| evict_valid | output | 1 | A line was replaced by this request |
| evict_addr | output | 16 | Address of the replaced line |
| evict_sharers | output | 16 | Sharer set of the replaced line |

## Verification
On every cycle, the assertions check the following:
- the ready/response handshake timing and the extra swap cycle;
- that an eviction only accompanies a missing response;
- that no tag matches two ways;
- that valid wide ways are never empty;
- that the recency ranks of the set being accessed stay a permutation.

The choice of wide way on overflow, the narrowing or coarsening of displaced contents, the allocation order and the identity of the evicted line can only be shown by the bench scenarios. These compare each response against an independent reference model. The scenarios run directed sequences built so that the single-sharer preference and the recency order pick different ways.

// File: rtl/hdir_pkg.sv
package hdir_pkg;
    typedef enum logic [1:0] {
        OP_LOOKUP = 2'd0,
        OP_ADD    = 2'd1,
        OP_REMOVE = 2'd2,
        OP_RSVD   = 2'd3
    } hd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_EXEC = 2'd1,
        ST_SWAP = 2'd2
    } hd_state_e;
endpackage

// File: rtl/hdir_ctrl.sv
module hdir_ctrl
    import hdir_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      req_valid,
    input  logic      overflow,
    output logic      req_ready,
    output logic      accept,
    output logic      commit,
    output hd_state_e state
);
    hd_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (req_valid) nxt = ST_EXEC;          // accept
            ST_EXEC: nxt = overflow ? ST_SWAP : ST_IDLE;   // overflow / finish
            ST_SWAP: nxt = ST_IDLE;                        // swap_done
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        req_ready = (state == ST_IDLE);
        accept    = req_ready && req_valid;
        commit    = ((state == ST_EXEC) && !overflow) || (state == ST_SWAP);
    end
endmodule

// File: rtl/hdir_lru.sv
module hdir_lru #(
    parameter  int NUM_SETS = 128,
    parameter  int NUM_WAYS = 8,
    localparam int IDX_W    = $clog2(NUM_SETS),
    localparam int WAY_W    = $clog2(NUM_WAYS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic [IDX_W-1:0]               rd_idx,
    output logic [NUM_WAYS-1:0][WAY_W-1:0] rank_rd,
    input  logic                           touch_en,
    input  logic [WAY_W-1:0]               touch_way
);
    logic [WAY_W-1:0] rank_q [NUM_SETS][NUM_WAYS];
    logic [NUM_WAYS-1:0] seen;

    always_comb begin
        for (int w = 0; w < NUM_WAYS; w++) rank_rd[w] = rank_q[rd_idx][w];
    end

    // rank 0 = most recent; larger = older
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int s = 0; s < NUM_SETS; s++)
                for (int w = 0; w < NUM_WAYS; w++)
                    rank_q[s][w] <= WAY_W'(w);
        end else if (touch_en) begin
            for (int w = 0; w < NUM_WAYS; w++) begin
                if (WAY_W'(w) == touch_way)
                    rank_q[rd_idx][w] <= '0;
                else if (rank_rd[w] < rank_rd[touch_way])
                    rank_q[rd_idx][w] <= rank_rd[w] + 1'b1;
            end
        end
    end

    always_comb begin
        seen = '0;
        for (int w = 0; w < NUM_WAYS; w++) seen[rank_rd[w]] = 1'b1;
    end

    AST_RANK_PERM: assert property (@(posedge clk) disable iff (!rst_n) $countones(seen) == NUM_WAYS); // R12
endmodule

// File: rtl/hdir_decode.sv
module hdir_decode #(
    parameter  int NUM_WAYS  = 8,
    parameter  int NUM_PTR   = 6,
    parameter  int NUM_CORES = 16,
    parameter  int TAG_W     = 9,
    localparam int WAY_W     = $clog2(NUM_WAYS)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  logic [NUM_WAYS-1:0]                valid_rd,
    input  logic [NUM_WAYS-1:0][TAG_W-1:0]     tag_rd,
    input  logic [NUM_WAYS-1:0][NUM_CORES-1:0] shr_rd,
    input  logic [NUM_WAYS-1:0][WAY_W-1:0]     rank_rd,
    input  logic [TAG_W-1:0]                   req_tag,
    output logic                               hit,
    output logic [WAY_W-1:0]                   hit_way,
    output logic                               free_ptr_ok,
    output logic [WAY_W-1:0]                   free_ptr_way,
    output logic                               free_vec_ok,
    output logic [WAY_W-1:0]                   free_vec_way,
    output logic [WAY_W-1:0]                   lru_ptr_way,
    output logic [WAY_W-1:0]                   swap_way
);
    logic [NUM_WAYS-1:0] hit_vec;
    logic                single_ok;
    logic [WAY_W-1:0]    single_way, lru_vec_way, best_rank;

    always_comb begin
        hit_vec = '0;
        hit_way = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            hit_vec[w] = valid_rd[w] && (tag_rd[w] == req_tag);
            if (hit_vec[w]) hit_way = WAY_W'(w);
        end
        hit = |hit_vec;

        free_ptr_ok  = 1'b0;
        free_ptr_way = '0;
        for (int w = NUM_PTR - 1; w >= 0; w--)
            if (!valid_rd[w]) begin
                free_ptr_ok  = 1'b1;
                free_ptr_way = WAY_W'(w);
            end

        free_vec_ok  = 1'b0;
        free_vec_way = '0;
        single_ok    = 1'b0;
        single_way   = '0;
        for (int w = NUM_WAYS - 1; w >= NUM_PTR; w--) begin
            if (!valid_rd[w]) begin
                free_vec_ok  = 1'b1;
                free_vec_way = WAY_W'(w);
            end
            if (valid_rd[w] && ($countones(shr_rd[w]) == 1)) begin
                single_ok  = 1'b1;
                single_way = WAY_W'(w);
            end
        end

        lru_ptr_way = '0;
        best_rank   = rank_rd[0];
        for (int w = 1; w < NUM_PTR; w++)
            if (rank_rd[w] > best_rank) begin
                best_rank   = rank_rd[w];
                lru_ptr_way = WAY_W'(w);
            end

        lru_vec_way = WAY_W'(NUM_PTR);
        best_rank   = rank_rd[NUM_PTR];
        for (int w = NUM_PTR + 1; w < NUM_WAYS; w++)
            if (rank_rd[w] > best_rank) begin
                best_rank   = rank_rd[w];
                lru_vec_way = WAY_W'(w);
            end

        swap_way = free_vec_ok ? free_vec_way : (single_ok ? single_way : lru_vec_way);
    end

    AST_ONE_HIT: assert property (@(posedge clk) disable iff (!rst_n) $onehot0(hit_vec)); // R11
endmodule

// File: rtl/hdir_top.sv
module hdir_top
    import hdir_pkg::*;
#(
    parameter  int NUM_CORES = 16,
    parameter  int NUM_SETS  = 128,
    parameter  int NUM_WAYS  = 8,
    parameter  int NUM_VEC   = 2,
    parameter  int ADDR_W    = 16,
    localparam int CORE_W    = $clog2(NUM_CORES),
    localparam int IDX_W     = $clog2(NUM_SETS),
    localparam int WAY_W     = $clog2(NUM_WAYS),
    localparam int TAG_W     = ADDR_W - IDX_W,
    localparam int NUM_PTR   = NUM_WAYS - NUM_VEC
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 req_valid,
    output logic                 req_ready,
    input  logic [1:0]           req_op,
    input  logic [ADDR_W-1:0]    req_addr,
    input  logic [CORE_W-1:0]    req_core,
    output logic                 rsp_valid,
    output logic                 rsp_hit,
    output logic [NUM_CORES-1:0] rsp_sharers,
    output logic                 evict_valid,
    output logic [ADDR_W-1:0]    evict_addr,
    output logic [NUM_CORES-1:0] evict_sharers
);
    hd_state_e            state;
    logic                 accept, commit, overflow;
    hd_op_e               op_r;
    logic [IDX_W-1:0]     idx_r;
    logic [TAG_W-1:0]     tag_r;
    logic [CORE_W-1:0]    core_r;

    logic [NUM_WAYS-1:0]                valid_rd;
    logic [NUM_WAYS-1:0][TAG_W-1:0]     tag_rd;
    logic [NUM_WAYS-1:0][NUM_CORES-1:0] shr_rd;
    logic [NUM_WAYS-1:0][WAY_W-1:0]     rank_rd;

    logic             hit, free_ptr_ok, free_vec_ok;
    logic [WAY_W-1:0] hit_way, free_ptr_way, free_vec_way, lru_ptr_way, swap_way;

    logic                 wa_en, wa_valid, wa_all, wb_en, wb_valid, wb_all;
    logic [WAY_W-1:0]     wa_way, wb_way, touch_way;
    logic [TAG_W-1:0]     wa_tag, wb_tag;
    logic [CORE_W-1:0]    wa_core, wb_core, sv_core;
    logic [NUM_CORES-1:0] wa_vec, oh, hit_shr, sv_shr, new_shr, res_shr, ev_shr;
    logic                 touch_en, res_hit, ev_en;
    logic [ADDR_W-1:0]    ev_addr;

    hdir_ctrl u_ctrl (
        .clk, .rst_n, .req_valid, .overflow,
        .req_ready, .accept, .commit, .state
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            op_r   <= OP_LOOKUP;
            idx_r  <= '0;
            tag_r  <= '0;
            core_r <= '0;
        end else if (accept) begin
            op_r   <= hd_op_e'(req_op);
            idx_r  <= req_addr[IDX_W-1:0];
            tag_r  <= req_addr[ADDR_W-1:IDX_W];
            core_r <= req_core;
        end
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        logic             vld_q [NUM_SETS];
        logic [TAG_W-1:0] tg_q  [NUM_SETS];
        logic             sel_a, sel_b;
        assign sel_a = wa_en && (wa_way == WAY_W'(w));
        assign sel_b = wb_en && (wb_way == WAY_W'(w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                for (int s = 0; s < NUM_SETS; s++) vld_q[s] <= 1'b0;
            end else if (sel_a) vld_q[idx_r] <= wa_valid;
            else if (sel_b)     vld_q[idx_r] <= wb_valid;
        end

        always_ff @(posedge clk) begin
            if (sel_a)      tg_q[idx_r] <= wa_tag;
            else if (sel_b) tg_q[idx_r] <= wb_tag;
        end

        assign valid_rd[w] = vld_q[idx_r];
        assign tag_rd[w]   = tg_q[idx_r];

        if (w < NUM_PTR) begin : g_ptr
            logic [CORE_W-1:0] cr_q  [NUM_SETS];
            logic              all_q [NUM_SETS];
            always_ff @(posedge clk) begin
                if (sel_a) begin
                    cr_q[idx_r]  <= wa_core;
                    all_q[idx_r] <= wa_all;
                end else if (sel_b) begin
                    cr_q[idx_r]  <= wb_core;
                    all_q[idx_r] <= wb_all;
                end
            end
            assign shr_rd[w] = all_q[idx_r] ? {NUM_CORES{1'b1}}
                                            : (NUM_CORES'(1) << cr_q[idx_r]);
        end else begin : g_vec
            logic [NUM_CORES-1:0] vc_q [NUM_SETS];
            always_ff @(posedge clk) begin
                if (sel_a) vc_q[idx_r] <= wa_vec;
            end
            assign shr_rd[w] = vc_q[idx_r];

            AST_VEC_NOT_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
                valid_rd[w] |-> (shr_rd[w] != '0)); // R10
        end
    end

    hdir_lru #(.NUM_SETS(NUM_SETS), .NUM_WAYS(NUM_WAYS)) u_lru (
        .clk, .rst_n, .rd_idx(idx_r), .rank_rd, .touch_en, .touch_way
    );

    hdir_decode #(.NUM_WAYS(NUM_WAYS), .NUM_PTR(NUM_PTR), .NUM_CORES(NUM_CORES), .TAG_W(TAG_W)) u_dec (
        .clk, .rst_n, .valid_rd, .tag_rd, .shr_rd, .rank_rd, .req_tag(tag_r),
        .hit, .hit_way, .free_ptr_ok, .free_ptr_way, .free_vec_ok, .free_vec_way,
        .lru_ptr_way, .swap_way
    );

    always_comb begin
        oh      = NUM_CORES'(1) << core_r;
        hit_shr = shr_rd[hit_way];
        sv_shr  = shr_rd[swap_way];
        new_shr = hit_shr & ~oh;
        sv_core = '0;
        for (int b = 0; b < NUM_CORES; b++) if (sv_shr[b]) sv_core = CORE_W'(b);

        wa_en = 1'b0; wa_way = '0; wa_valid = 1'b0; wa_tag = tag_r;
        wa_core = core_r; wa_all = 1'b0; wa_vec = oh;
        wb_en = 1'b0; wb_way = '0; wb_valid = 1'b0; wb_tag = tag_r;
        wb_core = '0; wb_all = 1'b0;
        touch_en = 1'b0; touch_way = hit_way;
        overflow = 1'b0; res_hit = 1'b0; res_shr = '0;
        ev_en = 1'b0; ev_addr = '0; ev_shr = '0;

        case (op_r)
            OP_ADD: begin
                if (hit) begin
                    res_hit  = 1'b1;
                    touch_en = 1'b1;
                    if (int'(hit_way) >= NUM_PTR) begin
                        wa_en = 1'b1; wa_way = hit_way; wa_valid = 1'b1;
                        wa_vec = hit_shr | oh;
                        res_shr = hit_shr | oh;
                    end else if ((hit_shr & oh) != '0) begin
                        res_shr = hit_shr;
                    end else begin
                        overflow = 1'b1;
                        wa_en = 1'b1; wa_way = swap_way; wa_valid = 1'b1;
                        wa_vec = hit_shr | oh;
                        wb_en = 1'b1; wb_way = hit_way; wb_valid = valid_rd[swap_way];
                        wb_tag = tag_rd[swap_way]; wb_core = sv_core;
                        wb_all = ($countones(sv_shr) != 1);
                        touch_way = swap_way;
                        res_shr = hit_shr | oh;
                    end
                end else begin
                    res_shr  = oh;
                    touch_en = 1'b1;
                    wa_en    = 1'b1;
                    wa_valid = 1'b1;
                    if (free_ptr_ok)      wa_way = free_ptr_way;
                    else if (free_vec_ok) wa_way = free_vec_way;
                    else begin
                        wa_way  = lru_ptr_way;
                        ev_en   = 1'b1;
                        ev_addr = {tag_rd[lru_ptr_way], idx_r};
                        ev_shr  = shr_rd[lru_ptr_way];
                    end
                    touch_way = wa_way;
                end
            end
            OP_REMOVE: begin
                if (hit) begin
                    res_hit  = 1'b1;
                    touch_en = 1'b1;
                    if (int'(hit_way) >= NUM_PTR) begin
                        wa_en = 1'b1; wa_way = hit_way;
                        wa_valid = (new_shr != '0); wa_vec = new_shr;
                        res_shr = new_shr;
                    end else if (hit_shr == {NUM_CORES{1'b1}}) begin
                        res_shr = hit_shr;
                    end else if (hit_shr == oh) begin
                        wa_en = 1'b1; wa_way = hit_way; wa_valid = 1'b0;
                        res_shr = '0;
                    end else begin
                        res_shr = hit_shr;
                    end
                end
            end
            default: begin
                res_hit  = hit;
                res_shr  = hit ? hit_shr : '0;
                touch_en = hit;
            end
        endcase

        if (!commit) begin
            wa_en    = 1'b0;
            wb_en    = 1'b0;
            touch_en = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rsp_valid     <= 1'b0;
            rsp_hit       <= 1'b0;
            rsp_sharers   <= '0;
            evict_valid   <= 1'b0;
            evict_addr    <= '0;
            evict_sharers <= '0;
        end else begin
            rsp_valid   <= commit;
            evict_valid <= commit && ev_en;
            if (commit) begin
                rsp_hit       <= res_hit;
                rsp_sharers   <= res_shr;
                evict_addr    <= ev_addr;
                evict_sharers <= ev_shr;
            end
        end
    end

    AST_ACCEPT_DROPS_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready); // R1
    AST_RSP_OR_SWAP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> ##1 (rsp_valid || !req_ready)); // R1
    AST_RSP_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid); // R1
    AST_SWAP_THEN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SWAP) |=> (rsp_valid && rsp_hit)); // R2
    AST_EVICT_IN_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        evict_valid |-> (rsp_valid && !rsp_hit)); // R7
endmodule

// File: tb/hdir_top_bench.sv
module hdir_top_bench;
    localparam int NS = 128;
    localparam int NW = 8;
    localparam int NP = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [1:0]  req_op = '0;
    logic [15:0] req_addr = '0;
    logic [3:0]  req_core = '0;
    logic        rsp_valid, rsp_hit, evict_valid;
    logic [15:0] rsp_sharers, evict_addr, evict_sharers;

    hdir_top u_hdir_top (
        .clk, .rst_n, .req_valid, .req_ready, .req_op, .req_addr, .req_core,
        .rsp_valid, .rsp_hit, .rsp_sharers, .evict_valid, .evict_addr, .evict_sharers
    );

    always #4 clk = ~clk;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic        mv [NS][NW];
    logic [8:0]  mt [NS][NW];
    logic [15:0] ms [NS][NW];
    int          mr [NS][NW];

    logic        last_hit, last_ev;
    logic [15:0] last_shr, last_eva;
    int          last_lat;

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [15:0] mk(input int s, input int t);
        return {t[8:0], s[6:0]};
    endfunction

    task automatic m_touch(input int s, input int w);
        int r = mr[s][w];
        for (int x = 0; x < NW; x++)
            if (x == w) mr[s][x] = 0;
            else if (mr[s][x] < r) mr[s][x]++;
    endtask

    task automatic m_apply(input int op, input logic [15:0] a, input int c,
                           output bit eh, output logic [15:0] es, output bit eo,
                           output bit ee, output logic [15:0] ea, output logic [15:0] esh);
        int s = int'(a[6:0]);
        logic [8:0] t = a[15:7];
        logic [15:0] oh = 16'(1) << c;
        int h = -1;
        eh = 0; es = '0; eo = 0; ee = 0; ea = '0; esh = '0;
        for (int w = 0; w < NW; w++) if (mv[s][w] && mt[s][w] == t) h = w;
        if (op == 1) begin
            if (h >= 0) begin
                eh = 1;
                if (h >= NP) begin
                    ms[s][h] |= oh; es = ms[s][h]; m_touch(s, h);
                end else if ((ms[s][h] & oh) != 0) begin
                    es = ms[s][h]; m_touch(s, h);
                end else begin
                    int v = -1;
                    logic dv; logic [8:0] dt; logic [15:0] ds;
                    for (int w = NP; w < NW; w++) if (!mv[s][w] && v < 0) v = w;
                    if (v < 0) for (int w = NP; w < NW; w++)
                        if ($countones(ms[s][w]) == 1 && v < 0) v = w;
                    if (v < 0) v = (mr[s][NP] > mr[s][NP+1]) ? NP : NP + 1;
                    dv = mv[s][v]; dt = mt[s][v]; ds = ms[s][v];
                    mv[s][v] = 1; mt[s][v] = t; ms[s][v] = ms[s][h] | oh; es = ms[s][v];
                    mv[s][h] = dv; mt[s][h] = dt;
                    ms[s][h] = ($countones(ds) == 1) ? ds : 16'hFFFF;
                    m_touch(s, v); eo = 1;
                end
            end else begin
                int f = -1;
                es = oh;
                for (int w = 0; w < NP; w++) if (!mv[s][w] && f < 0) f = w;
                if (f < 0) for (int w = NP; w < NW; w++) if (!mv[s][w] && f < 0) f = w;
                if (f < 0) begin
                    f = 0;
                    for (int w = 1; w < NP; w++) if (mr[s][w] > mr[s][f]) f = w;
                    ee = 1; ea = {mt[s][f], 7'(s)}; esh = ms[s][f];
                end
                mv[s][f] = 1; mt[s][f] = t; ms[s][f] = oh; m_touch(s, f);
            end
        end else if (op == 2) begin
            if (h >= 0) begin
                eh = 1; m_touch(s, h);
                if (h >= NP) begin
                    ms[s][h] &= ~oh;
                    if (ms[s][h] == 0) mv[s][h] = 0;
                    es = ms[s][h];
                end else if (ms[s][h] == 16'hFFFF) es = 16'hFFFF;
                else if (ms[s][h] == oh) begin mv[s][h] = 0; es = 0; end
                else es = ms[s][h];
            end
        end else begin
            if (h >= 0) begin eh = 1; es = ms[s][h]; m_touch(s, h); end
        end
    endtask

    task automatic do_req(input int op, input logic [15:0] a, input int c);
        bit eh, eo, ee; logic [15:0] es, ea, esh;
        int lat;
        m_apply(op, a, c, eh, es, eo, ee, ea, esh);
        @(negedge clk);
        check(req_ready == 1'b1, "R1 ready in idle", 32'(req_ready), 1);
        req_valid = 1'b1; req_op = 2'(op); req_addr = a; req_core = 4'(c);
        @(negedge clk);
        req_valid = 1'b0;
        lat = 1;
        check(req_ready == 1'b0, "R1 ready low after accept", 32'(req_ready), 0);
        while (!rsp_valid && lat < 6) begin
            @(negedge clk);
            lat++;
        end
        last_hit = rsp_hit; last_shr = rsp_sharers; last_ev = evict_valid;
        last_eva = evict_addr; last_lat = lat;
        check(lat == (eo ? 3 : 2), eo ? "R2 swap latency" : "R1 latency", 32'(lat), eo ? 3 : 2);
        check(rsp_hit == eh, "R3/R4 hit flag", 32'(rsp_hit), 32'(eh));
        check(rsp_sharers == es, "R4/R8/R9/R10 sharers", 32'(rsp_sharers), 32'(es));
        check(evict_valid == ee, "R7 evict flag", 32'(evict_valid), 32'(ee));
        if (ee) begin
            check(evict_addr == ea, "R7 evict address", 32'(evict_addr), 32'(ea));
            check(evict_sharers == esh, "R7 evict sharers", 32'(evict_sharers), 32'(esh));
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL R1 watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        for (int s = 0; s < NS; s++)
            for (int w = 0; w < NW; w++) begin
                mv[s][w] = 0; mt[s][w] = '0; ms[s][w] = '0; mr[s][w] = w;
            end
        repeat (4) @(negedge clk);
        check(req_ready == 1'b1, "R1 reset ready", 32'(req_ready), 1);
        check(rsp_valid == 1'b0, "R1 reset rsp_valid", 32'(rsp_valid), 0);
        check(evict_valid == 1'b0, "R7 reset evict_valid", 32'(evict_valid), 0);
        rst_n = 1'b1;

        // R3: lookup miss on empty directory
        do_req(0, mk(1, 5), 0);
        check(last_hit == 0 && last_shr == 0, "R3 empty lookup", 32'(last_shr), 0);

        // R6, R7: fill set 1, then evict the oldest narrow way
        for (int t = 1; t <= 8; t++) do_req(1, mk(1, t), t);
        do_req(1, mk(1, 9), 9);
        check(last_ev == 1 && last_eva == mk(1, 1), "R7 oldest narrow evicted", 32'(last_eva), 32'(mk(1, 1)));
        do_req(0, mk(1, 1), 0);
        check(last_hit == 0, "R7 evicted line gone", 32'(last_hit), 0);
        do_req(0, mk(1, 7), 0);
        check(last_shr == 16'h0080, "R6 wide-way fill", 32'(last_shr), 32'h80);

        // R8, R2: overflow into a free wide way
        do_req(1, mk(2, 1), 1);
        do_req(1, mk(2, 1), 2);
        check(last_lat == 3 && last_shr == 16'h0006, "R8 overflow to free wide way", 32'(last_shr), 32'h6);
        do_req(1, mk(2, 2), 3);
        do_req(0, mk(2, 1), 9);
        check(last_shr == 16'h0006, "R3 lookup after swap", 32'(last_shr), 32'h6);

        // R9: displaced multi-sharer becomes all-cores; R10 remove on it ignored
        do_req(1, mk(3, 1), 1); do_req(1, mk(3, 1), 2);
        do_req(1, mk(3, 2), 3); do_req(1, mk(3, 2), 4);
        do_req(1, mk(3, 3), 5); do_req(1, mk(3, 3), 6);
        do_req(0, mk(3, 1), 0);
        check(last_shr == 16'hFFFF, "R9 coarsened to all cores", 32'(last_shr), 32'hFFFF);
        do_req(2, mk(3, 1), 0);
        do_req(0, mk(3, 1), 0);
        check(last_shr == 16'hFFFF, "R10 all-cores remove ignored", 32'(last_shr), 32'hFFFF);
        do_req(1, mk(3, 1), 4);
        check(last_lat == 2 && last_shr == 16'hFFFF, "R5 add to all-cores", 32'(last_lat), 2);

        // R8: single-sharer wide way preferred over the older one
        do_req(2, mk(3, 2), 4);
        do_req(1, mk(3, 4), 7);
        do_req(1, mk(3, 4), 8);
        do_req(0, mk(3, 2), 0);
        check(last_shr == 16'h0008, "R9 narrowed to one pointer", 32'(last_shr), 32'h8);
        do_req(0, mk(3, 3), 0);
        check(last_shr == 16'h0060, "R8 older wide way kept", 32'(last_shr), 32'h60);
        do_req(1, mk(3, 2), 3);
        check(last_lat == 2 && last_shr == 16'h0008, "R5 same-core add", 32'(last_shr), 32'h8);

        // R10: remove to empty frees the way
        do_req(2, mk(3, 4), 7);
        do_req(2, mk(3, 4), 8);
        check(last_shr == 0, "R10 last sharer removed", 32'(last_shr), 0);
        do_req(0, mk(3, 4), 0);
        check(last_hit == 0, "R10 way freed", 32'(last_hit), 0);
        do_req(2, mk(3, 9), 1);
        check(last_hit == 0, "R10 remove miss", 32'(last_hit), 0);
        do_req(3, mk(3, 3), 0);
        check(last_shr == 16'h0060, "R3 code 3 as lookup", 32'(last_shr), 32'h60);

        // random mix (R3..R12 against the model)
        void'($urandom(32'd4242));
        for (int i = 0; i < 2500; i++) begin
            int r = int'($urandom % 10);
            int op = (r < 3) ? 0 : (r < 7) ? 1 : (r < 9) ? 2 : 3;
            do_req(op, mk(20 + int'($urandom % 4), int'($urandom % 10)), int'($urandom % 8));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule